// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends one frame from a reader to a card by gating the carrier. Each bit is first whitened: the data bit is XORed with the bit currently offered by an external keystream source. The encoded bit is then sent as a fixed carrier-off gap followed by a carrier-on stretch. The full length of the bit, gap included, tells the card whether a one or a zero was sent. The keystream source is told to step once per bit. After the final bit an extra gap closes the frame. The carrier then stays on, and a response timer restarts from zero so the card's reply can be measured from that instant.

All durations are counted in ticks of a tick-enable input, not in clock cycles. The surrounding logic can therefore pick the time base. A frame is requested with a one-cycle start strobe, a data word sent least-significant bit first, and a bit count. The count is clamped to the range one up to the data width.

Top module: `pp_frame_tx`

## Requirements
- R1: After reset the carrier output is high, `done` and `ks_adv` are low, and `resp_time` is zero until ticks arrive.
- R2: Data bits are sent least-significant first: bit i of `data_in` is the i-th bit on the air.
- R3: Every bit starts with a carrier-low gap of exactly 30 ticks.
- R4: Total bit time, gap included, is 150 ticks for an encoded 1 and 90 ticks for an encoded 0, so the carrier-high stretch is 120 or 60 ticks.
- R5: The encoded value of bit i is `data_in[i]` XOR the value of `ks_bit` after i keystream steps since the start strobe.
- R6: `ks_adv` pulses exactly once per transmitted bit, and only while the carrier is high within that bit.
- R7: After the last bit, one further carrier-low gap of 30 ticks is sent. The carrier then stays high until the next frame.
- R8: `done` is high for exactly one clock, in the cycle after the closing gap ends, and once per frame.
- R9: `resp_time` is zero in the cycle `done` is high. It then increases by one per tick, saturating at its maximum.
- R10: A start strobe that arrives while a frame is in progress is ignored and does not alter the frame on the air.
- R11: A bit count of 0 sends one bit. A bit count above 32 sends 32 bits.
- R12: Timing advances only on clocks where `tick_en` is high, so sparse ticks stretch the frame in clocks but not in ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick; all durations count these |
| start | input | 1 | One-cycle request to send a frame (ignored while busy) |
| data_in | input | 32 | Frame payload, LSB sent first |
| bit_count | input | 6 | Number of bits to send, clamped to 1..32 |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle request to step the keystream |
| carrier_on | output | 1 | Carrier enable, high while idle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the closing gap has ended |
| resp_time | output | 16 | Ticks since the last frame end, saturating |

## Verification
The assertions assume that `ks_bit` only changes in response to `ks_adv` and is steady when the block samples it. They also assume that `bit_count` and `data_in` are valid in the cycle of the start strobe. The bench meets this with a keystream model that steps only after seeing a `ks_adv` pulse, away from the active clock edge. Frame inputs are held stable around each start pulse. The bench measures every carrier run in ticks rather than clocks, so the checks stay valid when `tick_en` is thinned out.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GAP   = 2'd1,
    PH_MARK  = 2'd2,
    PH_CLOSE = 2'd3
  } pp_phase_t;
endpackage

// File: rtl/pp_tick_counter.sv
module pp_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pp_bit_shifter.sv
module pp_bit_shifter #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 6,
  parameter int LEFT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic [DATA_W-1:0]   data_in,
  input  logic [CNT_IN_W-1:0] count_in,
  output logic                next_bit,
  output logic                last_bit,
  output logic [LEFT_W-1:0]   bits_left
);
  logic [DATA_W-1:0] data_d, data_q;
  logic [LEFT_W-1:0] left_d, left_q;
  logic [LEFT_W-1:0] clamped;

  // Count clamp: zero becomes one, oversize becomes the full width
  always_comb begin
    if (count_in == '0)
      clamped = LEFT_W'(1);
    else if (LEFT_W'(count_in) > LEFT_W'(DATA_W) || (CNT_IN_W > LEFT_W && (count_in >> LEFT_W) != '0))
      clamped = LEFT_W'(DATA_W);
    else
      clamped = LEFT_W'(count_in);
  end

  always_comb begin
    data_d = data_q;
    left_d = left_q;
    if (load) begin
      data_d = data_in;
      left_d = clamped;
    end else if (shift) begin
      data_d = data_q >> 1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      left_q <= '0;
    end else begin
      data_q <= data_d;
      left_q <= left_d;
    end
  end

  assign next_bit  = data_q[1];
  assign last_bit  = (left_q == LEFT_W'(1));
  assign bits_left = left_q;
endmodule

// File: rtl/pp_resp_timer.sv
module pp_resp_timer #(
  parameter int RESP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick_en,
  output logic [RESP_W-1:0] value
);
  logic [RESP_W-1:0] val_d, val_q;

  always_comb begin
    val_d = val_q;
    if (clr)
      val_d = '0;
    else if (tick_en && (val_q != {RESP_W{1'b1}}))
      val_d = val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/pp_frame_tx.sv
module pp_frame_tx
  import pp_tx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int GAP_TICKS   = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int RESP_W      = 16,
  localparam int CNT_IN_W   = $clog2(DATA_W + 1),
  localparam int LEFT_W     = $clog2(DATA_W + 1),
  localparam int CNT_W      = $clog2(ONE_TICKS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                start,
  input  logic [DATA_W-1:0]   data_in,
  input  logic [CNT_IN_W-1:0] bit_count,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                carrier_on,
  output logic                busy,
  output logic                done,
  output logic [RESP_W-1:0]   resp_time
);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_TICKS - 1);
  localparam logic [CNT_W-1:0] ONE_END  = CNT_W'(ONE_TICKS - 1);
  localparam logic [CNT_W-1:0] ZERO_END = CNT_W'(ZERO_TICKS - 1);

  pp_phase_t        phase_d, phase_q;
  logic             enc_d, enc_q;
  logic             adv_d, adv_q;
  logic             done_d, done_q;
  logic             cnt_clr, cnt_inc;
  logic             sh_load, sh_shift;
  logic             resp_clr;
  logic             next_bit, last_bit;
  logic [LEFT_W-1:0] bits_left;
  logic [CNT_W-1:0] tick_cnt;
  logic             mark_end;

  pp_tick_counter #(.CNT_W(CNT_W)) i_tick_cnt (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (cnt_inc), .cnt (tick_cnt)
  );

  pp_bit_shifter #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W), .LEFT_W(LEFT_W)) i_shifter (
    .clk (clk), .rst_n (rst_n), .load (sh_load), .shift (sh_shift),
    .data_in (data_in), .count_in (bit_count),
    .next_bit (next_bit), .last_bit (last_bit), .bits_left (bits_left)
  );

  pp_resp_timer #(.RESP_W(RESP_W)) i_resp (
    .clk (clk), .rst_n (rst_n), .clr (resp_clr), .tick_en (tick_en), .value (resp_time)
  );

  assign mark_end = tick_en && (tick_cnt == (enc_q ? ONE_END : ZERO_END));

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    enc_d    = enc_q;
    adv_d    = 1'b0;
    done_d   = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = tick_en && (phase_q != PH_IDLE);
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    resp_clr = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_GAP;
          enc_d   = data_in[0] ^ ks_bit;
          sh_load = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      PH_GAP: begin
        if (tick_en && tick_cnt == GAP_END) begin
          phase_d = PH_MARK;
          adv_d   = 1'b1;
        end
      end
      PH_MARK: begin
        if (mark_end) begin
          cnt_clr = 1'b1;
          if (last_bit) begin
            phase_d = PH_CLOSE;
          end else begin
            phase_d  = PH_GAP;
            sh_shift = 1'b1;
            enc_d    = next_bit ^ ks_bit;
          end
        end
      end
      PH_CLOSE: begin
        if (tick_en && tick_cnt == GAP_END) begin
          phase_d  = PH_IDLE;
          done_d   = 1'b1;
          resp_clr = 1'b1;
          cnt_clr  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      enc_q   <= 1'b0;
      adv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      enc_q   <= enc_d;
      adv_q   <= adv_d;
      done_q  <= done_d;
    end
  end

  assign carrier_on = !((phase_q == PH_GAP) || (phase_q == PH_CLOSE));
  assign busy       = (phase_q != PH_IDLE);
  assign ks_adv     = adv_q;
  assign done       = done_q;

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP) |-> (tick_cnt <= GAP_END)); // R3
  AST_MARK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MARK) |-> (tick_cnt <= ONE_END)); // R4
  AST_ADV_IN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |-> carrier_on && busy); // R6
  AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!carrier_on)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RESP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (resp_time == '0)); // R9
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left <= LEFT_W'(DATA_W))); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mark_end) |=> $stable(bits_left)); // R10
endmodule

// File: tb/test_pp_frame_tx.sv
module test_pp_frame_tx;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        start;
  logic [31:0] data_in;
  logic [5:0]  bit_count;
  logic        ks_bit;
  logic        ks_adv;
  logic        carrier_on;
  logic        busy;
  logic        done;
  logic [15:0] resp_time;

  int errors = 0;
  int checks = 0;
  int tick_div = 0;
  logic [15:0] ks_state = 16'hACE1;

  // run monitor
  int  off_len [0:40];
  int  on_len  [0:40];
  int  n_off = 0, n_on = 0, adv_on = 0, adv_off = 0, done_cnt = 0, run_t = 0;
  logic prev_c = 1'b1;

  pp_frame_tx i_pp_frame_tx (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .start (start),
    .data_in (data_in), .bit_count (bit_count), .ks_bit (ks_bit),
    .ks_adv (ks_adv), .carrier_on (carrier_on), .busy (busy),
    .done (done), .resp_time (resp_time)
  );

  assign ks_bit = ks_state[0];

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // tick generator: one tick every tick_div clocks, none when zero
  initial begin
    int ph;
    ph = 0;
    tick_en = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (tick_div == 0) begin
        tick_en = 1'b0;
        ph = 0;
      end else begin
        tick_en = (ph == 0);
        ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
      end
    end
  end

  // carrier run monitor and keystream model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (carrier_on !== prev_c) begin
        if (prev_c == 1'b0) begin
          if (n_off < 41) off_len[n_off] = run_t;
          n_off++;
        end else if (n_off > 0) begin
          if (n_on < 41) on_len[n_on] = run_t;
          n_on++;
        end
        run_t  = 0;
        prev_c = carrier_on;
      end
      if (tick_en) run_t++;
      if (ks_adv) begin
        if (carrier_on) adv_on++; else adv_off++;
        ks_state = lfsr_next(ks_state);
      end
      if (done) done_cnt++;
    end
  end

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000 cycles", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    n_off = 0; n_on = 0; adv_on = 0; adv_off = 0; done_cnt = 0;
  endtask

  // one frame, checks on the air format, keystream use and frame end
  task automatic run_frame(input logic [31:0] d, input logic [5:0] cnt, input int nb,
                           input bit interfere);
    logic [15:0] s;
    logic [31:0] exp_w, got_w;
    int          t;
    bit          len_ok, gap_ok;
    s = ks_state;
    exp_w = '0;
    for (int i = 0; i < nb; i++) begin
      exp_w[i] = d[i] ^ s[0];
      s = lfsr_next(s);
    end
    mon_clear();
    @(posedge clk); #1;
    data_in = d; bit_count = cnt; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; data_in = ~d; bit_count = 6'd5;
    if (interfere) begin
      repeat (200) @(posedge clk);
      #1; start = 1'b1; data_in = 32'h0F0F_1234; bit_count = 6'd3;
      @(posedge clk); #1; start = 1'b0;
    end
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!done && t < 40000);
    check(done === 1'b1, "R8 done seen", done, 1);
    check(carrier_on === 1'b1, "R7 carrier high at done", carrier_on, 1);
    check(resp_time == 16'd0, "R9 resp_time cleared at done", resp_time, 0);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", done, 0);
    #1;
    check(n_off == nb + 1, "R3/R7 gap count", n_off, nb + 1);
    check(n_on == nb, "R4 mark count", n_on, nb);
    gap_ok = 1'b1;
    for (int i = 0; i < nb + 1 && i < 41; i++) if (off_len[i] != 30) gap_ok = 1'b0;
    check(gap_ok, "R3 gaps are 30 ticks", gap_ok, 1);
    check(n_off > 0 && n_off <= 41 && off_len[n_off-1] == 30, "R7 closing gap 30 ticks",
          (n_off > 0 && n_off <= 41) ? off_len[n_off-1] : -1, 30);
    len_ok = 1'b1;
    got_w = '0;
    for (int i = 0; i < nb && i < 41; i++) begin
      if (on_len[i] == 120) got_w[i] = 1'b1;
      else if (on_len[i] != 60) len_ok = 1'b0;
    end
    check(len_ok, "R4 bit lengths 150/90", len_ok, 1);
    check(got_w == exp_w, "R2/R5 decoded LSB-first word", got_w, exp_w);
    check(adv_on == nb, "R6 one ks_adv per bit", adv_on, nb);
    check(adv_off == 0, "R6 no ks_adv in gap", adv_off, 0);
    check(done_cnt == 1, "R8/R10 one done per frame", done_cnt, 1);
    repeat (40) @(negedge clk);
    check(carrier_on === 1'b1 && !busy, "R7 carrier stays high", carrier_on, 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(carrier_on === 1'b1, "R1 carrier after reset", carrier_on, 1);
    check(done === 1'b0 && ks_adv === 1'b0, "R1 done/ks_adv low", {done, ks_adv}, 0);
    check(resp_time == 16'd0, "R1 resp_time zero", resp_time, 0);
    check(busy === 1'b0, "R1 idle", busy, 0);
  endtask

  task automatic test_resp_count();
    tick_div = 1;
    run_frame(32'h0000_00B5, 6'd8, 8, 1'b0);
    mon_clear();
    @(negedge clk);
    while (!busy && resp_time != 16'd0 && 1'b0) @(negedge clk);
    // frame again, then count ten ticks after done
    @(posedge clk); #1; data_in = 32'h3; bit_count = 6'd2; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    do @(negedge clk); while (!done);
    repeat (10) @(negedge clk);
    check(resp_time == 16'd10, "R9 resp_time counts ticks", resp_time, 10);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; data_in = '0; bit_count = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();                                  // R1
    tick_div = 1;
    run_frame(32'h0000_0013, 6'd7, 7, 1'b0);       // R2 R3 R4 R5 R6 R7 R8
    run_frame(32'hDEAD_BEEF, 6'd32, 32, 1'b0);     // full width
    run_frame(32'h0000_0001, 6'd0, 1, 1'b0);       // R11 zero count
    run_frame(32'hA5C3_5A3C, 6'd40, 32, 1'b0);     // R11 oversize count
    run_frame(32'h0000_0F0F, 6'd16, 16, 1'b1);     // R10 start while busy
    tick_div = 3;
    run_frame(32'h0000_2C6, 6'd11, 11, 1'b0);      // R12 sparse ticks
    test_resp_count();                             // R9
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule